// File: doc/BRIEF.md
# Page-Mode Parallel EEPROM Write Controller

This block is a synthesizable behavioural model of the write side of a page-organized parallel EEPROM. A host drives active-low chip enable, output enable and write enable together with an address and a byte of data, all sampled on a system clock. Each control pin first passes through a synchronizer and a glitch filter. A write strobe is the interval in which both filtered chip enable and filtered write enable are low. Accepted strobes fill a page buffer. When no further strobe arrives within a load window, the block runs a timed internal cycle. That cycle erases the loaded locations to all ones and then programs them with the new data.

While a load or program cycle is pending, the block pulls a shared ready/busy line low through an output enable. The data pin of that line is always low, so several instances can be combined as a wired-OR. A write-lock input, meant to be tied to the host's reset during supply ramps, keeps the array unprogrammable while it is low. Reads return the array byte at the current address. During the internal cycle a read instead returns a polling byte.

Top module: `eep_write_ctrl`

## Requirements
- R1: The address is captured when a write strobe begins, which is when the later of chip enable and write enable goes low. The data is captured when the strobe ends, which is when the first of the two goes high. Address changes inside a strobe and data changes before its end do not redirect the write.
- R2: A low pulse of GLITCH_CYC clock cycles or fewer on chip enable, write enable or output enable is ignored. Such a pulse starts no write, enables no read output and leaves the array unchanged.
- R3: rdyBusyOe is 0 after reset and while idle. It is 1 from the cycle after the first accepted strobe until the internal cycle completes. rdyBusyOut is always 0.
- R4: Each program cycle erases every loaded location to 8'hFF and then writes the new byte. The stored value is therefore exactly the new data, whatever was there before. There is no bulk erase. After reset the whole array reads 8'hFF.
- R5: One load window accepts up to 2^OFS_BITS bytes of a single page, and all of them are written by one internal cycle.
- R6: While hostResetN is 0, write strobes are ignored and no cycle starts. If hostResetN goes to 0 during a load window, the loaded bytes are dropped and busy is released.
- R7: The page is addr[AW-1:OFS_BITS] of the first byte in a window, and the byte offset within the page is addr[OFS_BITS-1:0]. A byte whose page differs from the window's page is discarded.
- R8: The internal cycle begins LOAD_TO cycles after the last accepted strobe of a window and lasts PROG_CYC cycles. For a single-byte write, rdyBusyOe is high for exactly LOAD_TO+PROG_CYC cycles.
- R9: During the internal cycle, write strobes are ignored. A read returns {~b[7], b[6:0]}, where b is the last byte loaded.
- R10: Bytes of the page that were not loaded in the current window keep their previous contents.
- R11: dataOe is 1 exactly when filtered chip enable and output enable are low and filtered write enable is high. Outside the internal cycle, dataOut is the stored byte at addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of registers; the array is set to all ones |
| hostResetN | input | 1 | Active-low write lock tied to the host reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | PAGE_BITS+OFS_BITS | Byte address: page in upper bits, offset in lower |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or polling byte |
| dataOe | output | 1 | Read output enable |
| rdyBusyOe | output | 1 | Enable of the open-drain busy driver |
| rdyBusyOut | output | 1 | Busy driver data, constant low |

## Verification
The bench feeds pulses exactly GLITCH_CYC cycles wide on the write and output enables. A filter that counts one cycle too few would accept these pulses, raising busy or dataOe. It rewrites a byte from 8'h0F to 8'hF0, so a design that skips the erase stores 8'h00 instead of 8'hF0. It mixes foreign-page bytes into a window and checks that they do not land in either page. It moves the address partway through a strobe and checks that the byte still lands at the first address. It measures how long busy stays high, so an off-by-one in either timer shows up as a miscount. It reads during the internal cycle and strobes during it, so a design that programs mid-cycle or leaves out polling returns the wrong byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;    // latch address at strobe start
    logic firstByte;  // open window: set page, clear mask, store byte
    logic nextByte;   // store byte into the open window
    logic dropBuf;    // abandon the window
    logic erase;      // set loaded locations to all ones
    logic commit;     // write loaded bytes into the array
  } eep_strobe_t;
endpackage

// File: rtl/eep_deglitch.sv
module eep_deglitch #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawN,
  output logic cleanN
);
  localparam int CW = $clog2(GLITCH_CYC + 1) + 1;

  logic meta, syncN;
  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= 1'b1;
      syncN  <= 1'b1;
      cleanN <= 1'b1;
      runLen <= '0;
    end else begin
      meta  <= rawN;
      syncN <= meta;
      if (syncN == cleanN) begin
        runLen <= '0;
      end else if (runLen == CW'(GLITCH_CYC)) begin
        cleanN <= syncN;
        runLen <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int LOAD_TO  = 40,
  parameter int PROG_CYC = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostResetN,
  input  logic        ceF,
  input  logic        weF,
  input  logic        pageMatch,
  output eep_strobe_t strb,
  output logic        busyOe,
  output logic        inLoad,
  output logic        inProg
);
  localparam int MAXC = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  eep_state_e state, nextState;
  logic [TW-1:0] tick;
  logic wrAct, wrActQ, wrStart, wrEnd;

  assign wrAct   = !ceF && !weF;
  assign wrStart = wrAct && !wrActQ;
  assign wrEnd   = !wrAct && wrActQ;

  always_comb begin
    strb         = '0;
    strb.capAddr = wrStart;
    nextState    = state;
    unique case (state)
      ST_IDLE: begin
        if (wrEnd && hostResetN) begin
          strb.firstByte = 1'b1;
          nextState      = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (!hostResetN) begin
          strb.dropBuf = 1'b1;
          nextState    = ST_IDLE;
        end else if (wrEnd) begin
          strb.nextByte = pageMatch;
        end else if (!wrAct && tick == TW'(LOAD_TO - 1)) begin
          strb.erase = 1'b1;
          nextState  = ST_PROG;
        end
      end
      ST_PROG: begin
        if (tick == TW'(PROG_CYC - 1)) begin
          strb.commit = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tick   <= '0;
      wrActQ <= 1'b0;
    end else begin
      state  <= nextState;
      wrActQ <= wrAct;
      if (state != nextState || strb.nextByte || (state == ST_LOAD && wrAct))
        tick <= '0;
      else
        tick <= tick + 1'b1;
    end
  end

  assign busyOe = (state != ST_IDLE);
  assign inLoad = (state == ST_LOAD);
  assign inProg = (state == ST_PROG);
endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int PAGE_BITS = 4,
  parameter int OFS_BITS  = 7,
  parameter int DW        = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  eep_strobe_t                   strb,
  input  logic [PAGE_BITS+OFS_BITS-1:0] addr,
  input  logic [DW-1:0]                 dataIn,
  input  logic                          inProg,
  output logic                          pageMatch,
  output logic [DW-1:0]                 rdData
);
  localparam int AW         = PAGE_BITS + OFS_BITS;
  localparam int PAGE_BYTES = 1 << OFS_BITS;
  localparam int DEPTH      = 1 << AW;

  logic [DW-1:0]         mem     [DEPTH];
  logic [DW-1:0]         pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic [AW-1:0]         capAddrQ;
  logic [PAGE_BITS-1:0]  pageQ;
  logic [DW-1:0]         lastByte;
  logic [OFS_BITS-1:0]   capOfs;

  assign capOfs    = capAddrQ[OFS_BITS-1:0];
  assign pageMatch = (capAddrQ[AW-1:OFS_BITS] == pageQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddrQ <= '0;
      pageQ    <= '0;
      loaded   <= '0;
      lastByte <= '0;
    end else begin
      if (strb.capAddr) capAddrQ <= addr;
      if (strb.firstByte) begin
        pageQ    <= capAddrQ[AW-1:OFS_BITS];
        loaded   <= PAGE_BYTES'(1) << capOfs;
        lastByte <= dataIn;
      end else if (strb.nextByte) begin
        loaded[capOfs] <= 1'b1;
        lastByte       <= dataIn;
      end else if (strb.dropBuf || strb.commit) begin
        loaded <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.firstByte || strb.nextByte) pageBuf[capOfs] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (loaded[i] && strb.erase)  mem[{pageQ, OFS_BITS'(i)}] <= '1;
        if (loaded[i] && strb.commit) mem[{pageQ, OFS_BITS'(i)}] <= pageBuf[i];
      end
    end
  end

  assign rdData = inProg ? {~lastByte[DW-1], lastByte[DW-2:0]} : mem[addr];
endmodule

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl
  import eep_pkg::*;
#(
  parameter int PAGE_BITS  = 4,
  parameter int OFS_BITS   = 7,
  parameter int GLITCH_CYC = 3,
  parameter int LOAD_TO    = 40,
  parameter int PROG_CYC   = 200
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostResetN,
  input  logic                          ceN,
  input  logic                          oeN,
  input  logic                          weN,
  input  logic [PAGE_BITS+OFS_BITS-1:0] addr,
  input  logic [7:0]                    dataIn,
  output logic [7:0]                    dataOut,
  output logic                          dataOe,
  output logic                          rdyBusyOe,
  output logic                          rdyBusyOut
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] rawPins, cleanPins;
  logic ceF, oeF, weF;
  logic pageMatch, inLoad, inProg;
  eep_strobe_t strb;

  assign rawPins = {ceN, oeN, weN};

  for (genvar p = 0; p < NPIN; p++) begin : g_filt
    eep_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
      .clk(clk), .rstN(rstN), .rawN(rawPins[p]), .cleanN(cleanPins[p])
    );
  end

  assign {ceF, oeF, weF} = cleanPins;

  eep_ctrl #(.LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostResetN(hostResetN),
    .ceF(ceF), .weF(weF), .pageMatch(pageMatch),
    .strb(strb), .busyOe(rdyBusyOe), .inLoad(inLoad), .inProg(inProg)
  );

  eep_datapath #(.PAGE_BITS(PAGE_BITS), .OFS_BITS(OFS_BITS), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .inProg(inProg), .pageMatch(pageMatch), .rdData(dataOut)
  );

  assign dataOe     = !ceF && !oeF && weF;
  assign rdyBusyOut = 1'b0;
endmodule

// File: rtl/eep_write_checker.sv
module eep_write_checker #(
  parameter int PROG_CYC = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostResetN,
  input logic       rdyBusyOe,
  input logic       dataOe,
  input logic [7:0] dataOut,
  input logic       inLoad,
  input logic       inProg
);
  int progLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       progLen <= 0;
    else if (inProg) progLen <= progLen + 1;
    else             progLen <= 0;
  end

  // R6: locked and idle stays idle
  p_lock_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!hostResetN && !rdyBusyOe) |=> !rdyBusyOe);

  // R6: lock during a load window abandons it
  p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!hostResetN && inLoad) |=> (!inLoad && !inProg));

  // R3: busy is released only at the end of the internal cycle or on a dropped window
  p_busy_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyBusyOe) |-> ($past(inProg) || !$past(hostResetN)));

  // R8: internal cycle follows a load window and lasts PROG_CYC cycles
  p_prog_after_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inProg) |-> $past(inLoad));
  p_prog_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inProg) |-> (progLen == PROG_CYC));

  // R9: polling byte stays fixed while the internal cycle runs
  p_poll_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inProg && dataOe && $past(inProg && dataOe)) |-> $stable(dataOut));
endmodule

bind eep_write_ctrl eep_write_checker #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .hostResetN(hostResetN), .rdyBusyOe(rdyBusyOe),
  .dataOe(dataOe), .dataOut(dataOut), .inLoad(inLoad), .inProg(inProg)
);

// File: tb/sim_eep_write_ctrl.sv
module sim_eep_write_ctrl;
  localparam int PAGE_BITS  = 4;
  localparam int OFS_BITS   = 7;
  localparam int GLITCH_CYC = 3;
  localparam int LOAD_TO    = 40;
  localparam int PROG_CYC   = 200;
  localparam int AW         = PAGE_BITS + OFS_BITS;
  localparam int DEPTH      = 1 << AW;
  localparam int PB         = 1 << OFS_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostResetN = 1'b1;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe, rdyBusyOe, rdyBusyOut;

  logic [7:0] refMem [DEPTH];
  int nChk = 0, nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eep_write_ctrl #(.PAGE_BITS(PAGE_BITS), .OFS_BITS(OFS_BITS), .GLITCH_CYC(GLITCH_CYC),
                   .LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u0 (
    .clk(clk), .rstN(rstN), .hostResetN(hostResetN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdyBusyOe(rdyBusyOe), .rdyBusyOut(rdyBusyOut)
  );

  function automatic logic [AW-1:0] mkAddr(int pg, int ofs);
    return {PAGE_BITS'(pg), OFS_BITS'(ofs)};
  endfunction

  function automatic logic [7:0] pollByte(logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write strobe, chip enable already low
  task automatic strobe(logic [AW-1:0] a, logic [7:0] d);
    addr = a; dataIn = d; weN = 1'b0;
    tick(12);
    weN = 1'b1;
    tick(12);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (rdyBusyOe && n < 5000) begin tick(1); n++; end
    tick(2);
  endtask

  task automatic readCheck(logic [AW-1:0] a, string tag);
    ceN = 1'b0; oeN = 1'b0; addr = a;
    tick(10);
    check({tag, " R11 dataOe"}, dataOe, 1'b1);
    check(tag, dataOut, refMem[a]);
    oeN = 1'b1; ceN = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  initial begin
    int cnt, maxOe;
    logic [AW-1:0] a0, a1;
    logic [AW-1:0] wa [8];
    logic [7:0]    wd [8];
    bit            wk [8];
    int r;
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'hFF;
    r = $urandom(32'h5EED1234);
    tick(5);
    rstN = 1'b1;
    tick(3);

    // reset state (R3, R4)
    check("R3 reset busyOe", rdyBusyOe, 1'b0);
    check("R3 busy data low", rdyBusyOut, 1'b0);
    check("R11 reset dataOe", dataOe, 1'b0);
    readCheck(mkAddr(5, 9), "R4 erased after reset");

    // glitch on write enable (R2)
    ceN = 1'b0; addr = mkAddr(1, 1); dataIn = 8'h00;
    weN = 1'b0; tick(GLITCH_CYC); weN = 1'b1;
    cnt = 0;
    for (int i = 0; i < LOAD_TO + 20; i++) begin tick(1); cnt += int'(rdyBusyOe); end
    ceN = 1'b1;
    check("R2 we glitch busy cycles", cnt, 0);
    readCheck(mkAddr(1, 1), "R2 we glitch array");

    // glitch on output enable (R2)
    ceN = 1'b0; addr = mkAddr(1, 1);
    tick(10);
    maxOe = 0;
    oeN = 1'b0;
    for (int i = 0; i < GLITCH_CYC; i++) begin tick(1); maxOe |= int'(dataOe); end
    oeN = 1'b1;
    for (int i = 0; i < 10; i++) begin tick(1); maxOe |= int'(dataOe); end
    ceN = 1'b1;
    check("R2 oe glitch dataOe", maxOe, 0);

    // single byte, busy length (R8, R3)
    ceN = 1'b0; addr = mkAddr(2, 3); dataIn = 8'h0F; weN = 1'b0;
    tick(12); weN = 1'b1;
    cnt = 0;
    for (int i = 0; i < LOAD_TO + PROG_CYC + 60; i++) begin tick(1); cnt += int'(rdyBusyOe); end
    ceN = 1'b1;
    refMem[mkAddr(2, 3)] = 8'h0F;
    check("R8 busy length", cnt, LOAD_TO + PROG_CYC);
    readCheck(mkAddr(2, 3), "R8 single byte");

    // rewrite with complementary bits (R4)
    ceN = 1'b0; strobe(mkAddr(2, 3), 8'hF0); ceN = 1'b1;
    waitIdle();
    refMem[mkAddr(2, 3)] = 8'hF0;
    readCheck(mkAddr(2, 3), "R4 erase then program");

    // address fixed at start, data at end (R1)
    a0 = mkAddr(3, 10); a1 = mkAddr(3, 11);
    ceN = 1'b0; addr = a0; dataIn = 8'h11; weN = 1'b0;
    tick(12); addr = a1; dataIn = 8'h22;
    tick(4); weN = 1'b1;
    tick(12); ceN = 1'b1;
    waitIdle();
    refMem[a0] = 8'h22;
    readCheck(a0, "R1 addr at start data at end");
    readCheck(a1, "R1 moved addr untouched");

    // chip-enable controlled strobe (R1)
    addr = mkAddr(3, 20); dataIn = 8'h6B; weN = 1'b0;
    tick(4); ceN = 1'b0; tick(12); ceN = 1'b1; tick(12); weN = 1'b1;
    waitIdle();
    refMem[mkAddr(3, 20)] = 8'h6B;
    readCheck(mkAddr(3, 20), "R1 ce controlled");

    // polling and ignored strobe during internal cycle (R9)
    ceN = 1'b0; addr = mkAddr(4, 0); dataIn = 8'h5A; weN = 1'b0;
    tick(12); weN = 1'b1;
    tick(LOAD_TO + 20);
    oeN = 1'b0; tick(10);
    check("R9 polling byte", dataOut, pollByte(8'h5A));
    oeN = 1'b1; tick(8);
    strobe(mkAddr(4, 1), 8'h33);
    check("R9 still busy", rdyBusyOe, 1'b1);
    ceN = 1'b1;
    waitIdle();
    refMem[mkAddr(4, 0)] = 8'h5A;
    readCheck(mkAddr(4, 0), "R9 programmed byte");
    readCheck(mkAddr(4, 1), "R9 strobe in cycle ignored");

    // lock while idle (R6)
    hostResetN = 1'b0;
    ceN = 1'b0; strobe(mkAddr(6, 6), 8'h00);
    cnt = 0;
    for (int i = 0; i < LOAD_TO + 10; i++) begin tick(1); cnt += int'(rdyBusyOe); end
    ceN = 1'b1; hostResetN = 1'b1;
    check("R6 locked busy cycles", cnt, 0);
    readCheck(mkAddr(6, 6), "R6 locked array");

    // lock during load window (R6)
    ceN = 1'b0; strobe(mkAddr(6, 7), 8'h00); ceN = 1'b1;
    hostResetN = 1'b0; tick(3);
    check("R6 drop busy", rdyBusyOe, 1'b0);
    tick(LOAD_TO + PROG_CYC); hostResetN = 1'b1;
    readCheck(mkAddr(6, 7), "R6 dropped window");

    // foreign page discarded, rest of page kept (R7, R10)
    ceN = 1'b0;
    strobe(mkAddr(2, 40), 8'hA1);
    strobe(mkAddr(7, 41), 8'hA2);
    strobe(mkAddr(2, 42), 8'hA3);
    ceN = 1'b1;
    waitIdle();
    refMem[mkAddr(2, 40)] = 8'hA1; refMem[mkAddr(2, 42)] = 8'hA3;
    readCheck(mkAddr(2, 40), "R7 first page byte");
    readCheck(mkAddr(2, 42), "R7 later page byte");
    readCheck(mkAddr(7, 41), "R7 foreign page dropped");
    readCheck(mkAddr(2, 41), "R7 offset not loaded");
    readCheck(mkAddr(2, 3), "R10 earlier byte kept");

    // full page in one window (R5)
    ceN = 1'b0;
    for (int i = 0; i < PB; i++) strobe(mkAddr(9, i), 8'(i ^ 8'h3C));
    ceN = 1'b1;
    waitIdle();
    for (int i = 0; i < PB; i++) refMem[mkAddr(9, i)] = 8'(i ^ 8'h3C);
    for (int i = 0; i < PB; i++) readCheck(mkAddr(9, i), "R5 full page");

    // random windows (R5, R7, R10)
    for (int t = 0; t < 20; t++) begin
      int pg, nb;
      pg = int'($urandom_range(PAGE_BITS'((1 << PAGE_BITS) - 1), 0));
      nb = int'($urandom_range(8, 1));
      ceN = 1'b0;
      for (int k = 0; k < nb; k++) begin
        int p2;
        p2 = (k > 0 && $urandom_range(4, 0) == 0) ? ((pg + 1) % (1 << PAGE_BITS)) : pg;
        wa[k] = mkAddr(p2, int'($urandom_range(PB - 1, 0)));
        wd[k] = 8'($urandom);
        wk[k] = (p2 == pg);
        strobe(wa[k], wd[k]);
      end
      ceN = 1'b1;
      waitIdle();
      for (int k = 0; k < nb; k++) if (wk[k]) refMem[wa[k]] = wd[k];
      for (int k = 0; k < nb; k++) readCheck(wa[k], "R7 random window");
      readCheck(mkAddr(pg, int'($urandom_range(PB - 1, 0))), "R10 random neighbour");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule